// File: doc/BRIEF.md
# Setup-Gated Extension Register Decoder

This block sits on a display adapter's 16-bit I/O bus and decides which of its configuration registers an I/O cycle addresses. A setup-control port sets a setup-mode flag and an adapter-enable flag. While setup mode is active, a small window of setup-only registers appears: a two-byte card identifier, a global enable, a multiple-enable control byte and a fixed global identifier. Outside setup mode that window does not decode at all.

The block also has an index/data pair for extension registers, backed by a 256 x 8 register array. One multiple-enable bit places the pair in either the monochrome or the colour I/O range. Another multiple-enable bit must be set before the data port may be used. One bit held inside the extension array itself narrows every address compare to the low 10 bits. Each accepted data-port write is also reported on a strobe with its index and data, for extension logic outside the block.

Reads are combinational: read data and the hit flag follow the address within the same cycle. Writes take effect at the next rising clock edge.

Top module: `ext_reg_decoder`

## Requirements
- R1: In the first cycle after a synchronous active-low reset, setup_mode, adapter_en, vga_en and ext_wr_stb are 0. The extension index, the multiple-enable byte and the global-enable byte all read as 0x00.
- R2: A write to port 0x46E8 loads setup_mode from data bit 4 and adapter_en from data bit 3. A read of that port returns those two flags in the same bit positions, with all other bits 0.
- R3: Ports 0x100 to 0x104 decode only while setup_mode is 1. When it is 0, a read of those ports gives io_hit=0 and data 0xFF, and a write to them changes nothing.
- R4: In setup mode, port 0x100 reads the low byte of the CARD_ID parameter, port 0x101 reads its high byte, and port 0x104 reads the constant 0xA5.
- R5: In setup mode, a write to port 0x102 loads bit 0 of the data onto vga_en. A read of that port returns {7'b0, vga_en}.
- R6: In setup mode, port 0x103 holds an 8-bit multiple-enable byte that can be read back. When bit 6 of this byte is 1, the index/data pair decodes at 0x3B6/0x3B7. When bit 6 is 0, the pair decodes at 0x3D6/0x3D7. The pair that is not selected does not decode.
- R7: While multiple-enable bit 7 is 0, a data-port read gives io_hit=1 and data 0xFF, and a data-port write neither changes the array nor raises ext_wr_stb. The index port stays writable and readable.
- R8: While multiple-enable bit 7 is 1, a data-port write stores the byte at the current index. In the cycle after that write, ext_wr_stb is 1 and ext_wr_idx and ext_wr_data carry the index and the byte. A data-port read returns the stored byte.
- R9: When bit 5 of extension register 2 is 1, every port compare uses only address bits 9:0. When that bit is 0, every port compare uses all 16 bits.
- R10: A read of any address that decodes to no register gives io_hit=0 and data 0xFF. A write to such an address changes no state and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; 0xFF when nothing decodes |
| io_hit | output | 1 | Read cycle decodes to a visible register |
| setup_mode | output | 1 | Setup mode active |
| adapter_en | output | 1 | Adapter enable flag |
| vga_en | output | 1 | Global display function enable |
| ext_wr_stb | output | 1 | One-cycle strobe for an accepted data-port write |
| ext_wr_idx | output | 8 | Index of that write |
| ext_wr_data | output | 8 | Data of that write |

## Verification
Decoding is exercised with the same register ports reached under four conditions: setup mode off and on, the pair in each of its two ranges, the data gate closed and open, and 16-bit versus 10-bit compare. Aliased addresses such as 0x43B6 and 0xC104 tell the two compare widths apart, because they hit only when the compare is narrow. Writes made while the gate is closed, followed by a read after the gate opens, show that the closed gate blocks the write itself and does not only mask the read. A write to the multiple-enable port made outside setup mode, followed by a gated data read, shows that the hidden write really had no effect.

// File: rtl/ext_decode_pkg.sv
// Package: shared constants for the extension register decoder.
// Holds the I/O port map, the control bit positions and the fixed ID value.
// Assumes a 16-bit I/O address and byte-wide registers.
package ext_decode_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Decoded port slots; the order indexes PORT_ADDR
    typedef enum int unsigned {
        PT_SETUP_CTL = 0,
        PT_CARD_LO,
        PT_CARD_HI,
        PT_GLB_EN,
        PT_MULTI_EN,
        PT_GLB_ID,
        PT_IDX_MONO,
        PT_DAT_MONO,
        PT_IDX_COLOR,
        PT_DAT_COLOR,
        PT_COUNT
    } port_e;

    localparam int NUM_PORTS = int'(PT_COUNT);

    localparam logic [ADDR_W-1:0] PORT_ADDR [NUM_PORTS] = '{
        16'h46E8, 16'h0100, 16'h0101, 16'h0102, 16'h0103,
        16'h0104, 16'h03B6, 16'h03B7, 16'h03D6, 16'h03D7
    };

    localparam int SC_SETUP_BIT   = 4;
    localparam int SC_ADAPTER_BIT = 3;
    localparam int GE_VGA_BIT     = 0;
    localparam int ME_RELOC_BIT   = 6;
    localparam int ME_GATE_BIT    = 7;

    localparam int NARROW_REG_IDX = 2;
    localparam int NARROW_REG_BIT = 5;

    localparam logic [DATA_W-1:0] GLOBAL_ID = 8'hA5;
    localparam logic [DATA_W-1:0] IDLE_DATA = 8'hFF;

endpackage

// File: rtl/ext_port_match.sv
// Module: compares one I/O address against one fixed port address.
// When NARROW_W is below the address width, the narrow input picks a
// compare of only the low NARROW_W bits. Purely combinational.
module ext_port_match
    import ext_decode_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT     = '0,
    parameter int                NARROW_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              narrow,
    output logic              hit
);

    generate
        if (NARROW_W < ADDR_W) begin : g_dual
            // Compare width chosen at run time
            always_comb begin
                if (narrow) hit = (addr[NARROW_W-1:0] == PORT[NARROW_W-1:0]);
                else        hit = (addr == PORT);
            end
        end else begin : g_full
            logic unused_narrow;
            // Narrowing has no meaning at full width; compare all bits
            always_comb begin
                unused_narrow = narrow;
                hit = (addr == PORT);
            end
        end
    endgenerate

endmodule

// File: rtl/ext_setup_regs.sv
// Module: setup-control, global-enable and multiple-enable registers.
// Assumes every select input is already qualified by address and mode.
// Writes land on the rising edge; reset clears all of them.
module ext_setup_regs
    import ext_decode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              sel_ctl,
    input  logic              sel_gen,
    input  logic              sel_men,
    output logic              setup_mode,
    output logic              adapter_en,
    output logic              vga_en,
    output logic [DATA_W-1:0] men_q,
    output logic [DATA_W-1:0] ctl_rd,
    output logic [DATA_W-1:0] gen_rd
);

    // Register updates for the three control bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_mode <= 1'b0;
            adapter_en <= 1'b0;
            vga_en     <= 1'b0;
            men_q      <= '0;
        end else if (io_wr) begin
            if (sel_ctl) begin
                setup_mode <= io_wdata[SC_SETUP_BIT];
                adapter_en <= io_wdata[SC_ADAPTER_BIT];
            end
            if (sel_gen) vga_en <= io_wdata[GE_VGA_BIT];
            if (sel_men) men_q  <= io_wdata;
        end
    end

    // Readback images of the bit-wise registers
    always_comb begin
        ctl_rd = '0;
        ctl_rd[SC_SETUP_BIT]   = setup_mode;
        ctl_rd[SC_ADAPTER_BIT] = adapter_en;
        gen_rd = '0;
        gen_rd[GE_VGA_BIT] = vga_en;
    end

endmodule

// File: rtl/ext_index_file.sv
// Module: extension index register, extension register array and write strobe.
// Assumes sel_dat is already qualified by the data-port gate.
// The array is made of flops so that one bit of it can drive the decode width.
module ext_index_file
    import ext_decode_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              sel_idx,
    input  logic              sel_dat,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] dat_rd,
    output logic              narrow,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] regs [DEPTH];

    // Index register load
    always_ff @(posedge clk) begin
        if (!rst_n)                 idx_q <= '0;
        else if (io_wr && sel_idx)  idx_q <= io_wdata[IDX_W-1:0];
    end

    // Array write through the data port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (io_wr && sel_dat) begin
            regs[idx_q] <= io_wdata;
        end
    end

    // Strobe with index and data, one cycle after an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= io_wr && sel_dat;
            if (io_wr && sel_dat) begin
                wr_idx  <= idx_q;
                wr_data <= io_wdata;
            end
        end
    end

    // Data-port readback and decode-width flag
    always_comb begin
        dat_rd = regs[idx_q];
        narrow = regs[NARROW_REG_IDX][NARROW_REG_BIT];
    end

endmodule

// File: rtl/ext_reg_decoder.sv
// Module (top): decodes I/O cycles for the setup and extension register space.
// Assumes single-cycle I/O strobes and never both strobes in one cycle.
// Reads are combinational; writes take effect at the next rising edge.
module ext_reg_decoder
    import ext_decode_pkg::*;
#(
    parameter logic [15:0] CARD_ID  = 16'h6A3C,
    parameter int          NARROW_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_hit,
    output logic              setup_mode,
    output logic              adapter_en,
    output logic              vga_en,
    output logic              ext_wr_stb,
    output logic [7:0]        ext_wr_idx,
    output logic [7:0]        ext_wr_data
);

    localparam int IDX_W = 8;

    logic [NUM_PORTS-1:0] port_hit;
    logic                 narrow;
    logic [DATA_W-1:0]    men_q, ctl_rd, gen_rd, dat_rd;
    logic [IDX_W-1:0]     idx_q;
    logic sel_ctl, sel_cid_lo, sel_cid_hi, sel_gen, sel_men, sel_gid;
    logic sel_idx, sel_dat_raw, sel_dat_open;

    // One comparator per port in the map
    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_match
            ext_port_match #(.PORT(PORT_ADDR[g]), .NARROW_W(NARROW_W)) i_match (
                .addr   (io_addr),
                .narrow (narrow),
                .hit    (port_hit[g])
            );
        end
    endgenerate

    // Qualify raw hits with setup mode, pair location and data gate
    always_comb begin
        sel_ctl    = port_hit[PT_SETUP_CTL];
        sel_cid_lo = setup_mode && port_hit[PT_CARD_LO];
        sel_cid_hi = setup_mode && port_hit[PT_CARD_HI];
        sel_gen    = setup_mode && port_hit[PT_GLB_EN];
        sel_men    = setup_mode && port_hit[PT_MULTI_EN];
        sel_gid    = setup_mode && port_hit[PT_GLB_ID];
        if (men_q[ME_RELOC_BIT]) begin
            sel_idx     = port_hit[PT_IDX_MONO];
            sel_dat_raw = port_hit[PT_DAT_MONO];
        end else begin
            sel_idx     = port_hit[PT_IDX_COLOR];
            sel_dat_raw = port_hit[PT_DAT_COLOR];
        end
        sel_dat_open = sel_dat_raw && men_q[ME_GATE_BIT];
    end

    ext_setup_regs i_setup (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .sel_ctl    (sel_ctl),
        .sel_gen    (sel_gen),
        .sel_men    (sel_men),
        .setup_mode (setup_mode),
        .adapter_en (adapter_en),
        .vga_en     (vga_en),
        .men_q      (men_q),
        .ctl_rd     (ctl_rd),
        .gen_rd     (gen_rd)
    );

    ext_index_file #(.IDX_W(IDX_W)) i_xfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .sel_idx  (sel_idx),
        .sel_dat  (sel_dat_open),
        .idx_q    (idx_q),
        .dat_rd   (dat_rd),
        .narrow   (narrow),
        .wr_stb   (ext_wr_stb),
        .wr_idx   (ext_wr_idx),
        .wr_data  (ext_wr_data)
    );

    // Read data mux and hit flag
    always_comb begin
        io_hit   = 1'b0;
        io_rdata = IDLE_DATA;
        if (io_rd) begin
            io_hit = 1'b1;
            if (sel_ctl)          io_rdata = ctl_rd;
            else if (sel_cid_lo)  io_rdata = CARD_ID[7:0];
            else if (sel_cid_hi)  io_rdata = CARD_ID[15:8];
            else if (sel_gen)     io_rdata = gen_rd;
            else if (sel_men)     io_rdata = men_q;
            else if (sel_gid)     io_rdata = GLOBAL_ID;
            else if (sel_idx)     io_rdata = idx_q;
            else if (sel_dat_raw) io_rdata = sel_dat_open ? dat_rd : IDLE_DATA;
            else                  io_hit   = 1'b0;
        end
    end

endmodule

// File: rtl/ext_decoder_checker.sv
// Module: property checker for ext_reg_decoder, attached with bind below.
// Watches ports plus the multiple-enable byte; drives nothing.
module ext_decoder_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic [7:0]  io_wdata,
    input logic [7:0]  io_rdata,
    input logic        io_hit,
    input logic        setup_mode,
    input logic        adapter_en,
    input logic        vga_en,
    input logic        ext_wr_stb,
    input logic [7:0]  men_q
);

    logic was_rst = 1'b0;

    // Tracks that the previous edge saw reset asserted
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
        if (rst_n && was_rst)
            a_r1_reset_clear: assert (!setup_mode && !adapter_en && !vga_en && !ext_wr_stb);
    end

    a_r2_setup_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_mode) |-> $past(io_wr && io_wdata[4]));

    a_r3_hidden_outside_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !setup_mode && io_addr >= 16'h0100 && io_addr <= 16'h0104) |-> !io_hit);

    a_r4_global_id: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && setup_mode && io_addr == 16'h0104) |-> (io_rdata == 8'hA5));

    a_r5_vga_from_setup_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vga_en) |-> $past(io_wr && setup_mode && io_addr[9:0] == 10'h102));

    a_r7_strobe_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ext_wr_stb |-> $past(io_wr && men_q[7]));

endmodule

bind ext_reg_decoder ext_decoder_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr    (io_addr),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .io_hit     (io_hit),
    .setup_mode (setup_mode),
    .adapter_en (adapter_en),
    .vga_en     (vga_en),
    .ext_wr_stb (ext_wr_stb),
    .men_q      (men_q)
);

// File: tb/test_ext_reg_decoder.sv
module test_ext_reg_decoder;

    localparam logic [15:0] CID = 16'hC3E1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata, ext_wr_idx, ext_wr_data;
    logic        io_hit, setup_mode, adapter_en, vga_en, ext_wr_stb;

    int checks = 0, fails = 0;

    // Behavioural reference state
    bit       m_setup, m_adp, m_gen, m_stb;
    bit [7:0] m_men, m_idx, m_si, m_sd;
    bit [7:0] m_arr [256];
    bit       last_hit;
    bit [7:0] last_data;

    always #5 clk = ~clk;

    ext_reg_decoder #(.CARD_ID(CID)) i_ext_reg_decoder (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
        .setup_mode(setup_mode), .adapter_en(adapter_en), .vga_en(vga_en),
        .ext_wr_stb(ext_wr_stb), .ext_wr_idx(ext_wr_idx), .ext_wr_data(ext_wr_data)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit mt(input bit [15:0] a, input bit [15:0] p);
        if (m_arr[2][5]) return a[9:0] == p[9:0];
        return a == p;
    endfunction

    function automatic void mread(input bit [15:0] a, output bit h, output bit [7:0] d);
        bit [15:0] ip = m_men[6] ? 16'h03B6 : 16'h03D6;
        h = 1'b1;
        d = 8'hFF;
        if (mt(a, 16'h46E8))                d = {3'b0, m_setup, m_adp, 3'b0};
        else if (m_setup && mt(a, 16'h0100)) d = CID[7:0];
        else if (m_setup && mt(a, 16'h0101)) d = CID[15:8];
        else if (m_setup && mt(a, 16'h0102)) d = {7'b0, m_gen};
        else if (m_setup && mt(a, 16'h0103)) d = m_men;
        else if (m_setup && mt(a, 16'h0104)) d = 8'hA5;
        else if (mt(a, ip))                  d = m_idx;
        else if (mt(a, ip + 16'd1))          d = m_men[7] ? m_arr[m_idx] : 8'hFF;
        else                                 h = 1'b0;
    endfunction

    // One bus cycle, with a full model comparison
    task automatic cyc(input bit rd, input bit wr, input bit [15:0] a, input bit [7:0] d);
        bit h;
        bit [7:0] e;
        bit [15:0] ip;
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
        #2;
        last_hit = io_hit;
        last_data = io_rdata;
        if (rd) begin
            mread(a, h, e);
            chk("R10 model io_hit", {15'b0, io_hit}, {15'b0, h});
            chk("R8 model io_rdata", {8'b0, io_rdata}, {8'b0, e});
        end
        ip = m_men[6] ? 16'h03B6 : 16'h03D6;
        m_stb = 1'b0;
        if (wr) begin
            if (mt(a, 16'h46E8)) begin m_setup = d[4]; m_adp = d[3]; end
            else if (m_setup && mt(a, 16'h0102)) m_gen = d[0];
            else if (m_setup && mt(a, 16'h0103)) m_men = d;
            else if (mt(a, ip)) m_idx = d;
            else if (mt(a, ip + 16'd1) && m_men[7]) begin
                m_arr[m_idx] = d; m_stb = 1'b1; m_si = m_idx; m_sd = d;
            end
        end
        @(posedge clk);
        #1;
        chk("R2 model setup_mode", {15'b0, setup_mode}, {15'b0, m_setup});
        chk("R2 model adapter_en", {15'b0, adapter_en}, {15'b0, m_adp});
        chk("R5 model vga_en", {15'b0, vga_en}, {15'b0, m_gen});
        chk("R7 model ext_wr_stb", {15'b0, ext_wr_stb}, {15'b0, m_stb});
        if (m_stb) begin
            chk("R8 model ext_wr_idx", {8'b0, ext_wr_idx}, {8'b0, m_si});
            chk("R8 model ext_wr_data", {8'b0, ext_wr_data}, {8'b0, m_sd});
        end
        io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic wr(input bit [15:0] a, input bit [7:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic rdx(input string tag, input bit [15:0] a, input bit h, input bit [7:0] d);
        cyc(1'b1, 1'b0, a, 8'h00);
        chk({tag, " hit"}, {15'b0, last_hit}, {15'b0, h});
        chk({tag, " data"}, {8'b0, last_data}, {8'b0, d});
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        foreach (m_arr[i]) m_arr[i] = 8'h00;
        {m_setup, m_adp, m_gen, m_stb} = '0;
        m_men = 0; m_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset setup_mode", {15'b0, setup_mode}, 16'h0);
        chk("R1 reset adapter_en", {15'b0, adapter_en}, 16'h0);
        chk("R1 reset vga_en", {15'b0, vga_en}, 16'h0);
        chk("R1 reset ext_wr_stb", {15'b0, ext_wr_stb}, 16'h0);

        rdx("R3 card id hidden", 16'h0100, 1'b0, 8'hFF);
        wr(16'h0102, 8'h01);
        chk("R3 hidden write ignored", {15'b0, vga_en}, 16'h0);
        wr(16'h46E8, 8'h18);
        chk("R2 setup entered", {14'b0, setup_mode, adapter_en}, 16'h3);
        rdx("R2 control readback", 16'h46E8, 1'b1, 8'h18);
        rdx("R1 multi enable clear", 16'h0103, 1'b1, 8'h00);
        rdx("R1 global enable clear", 16'h0102, 1'b1, 8'h00);
        rdx("R1 index clear", 16'h03D6, 1'b1, 8'h00);
        rdx("R4 card id low", 16'h0100, 1'b1, CID[7:0]);
        rdx("R4 card id high", 16'h0101, 1'b1, CID[15:8]);
        rdx("R4 global id", 16'h0104, 1'b1, 8'hA5);

        wr(16'h0102, 8'h01);
        chk("R5 vga enabled", {15'b0, vga_en}, 16'h1);
        rdx("R5 global enable readback", 16'h0102, 1'b1, 8'h01);

        wr(16'h03D6, 8'h40);
        rdx("R6 colour index", 16'h03D6, 1'b1, 8'h40);
        rdx("R6 mono pair off", 16'h03B6, 1'b0, 8'hFF);
        wr(16'h03D7, 8'h55);
        chk("R7 closed gate no strobe", {15'b0, ext_wr_stb}, 16'h0);
        rdx("R7 closed gate read", 16'h03D7, 1'b1, 8'hFF);
        wr(16'h0103, 8'h80);
        wr(16'h03D7, 8'h55);
        chk("R8 strobe", {15'b0, ext_wr_stb}, 16'h1);
        chk("R8 strobe index and data", {ext_wr_idx, ext_wr_data}, 16'h4055);
        rdx("R8 data readback", 16'h03D7, 1'b1, 8'h55);
        wr(16'h0103, 8'h00);
        wr(16'h03D7, 8'h77);
        wr(16'h0103, 8'h80);
        rdx("R7 closed write dropped", 16'h03D7, 1'b1, 8'h55);

        wr(16'h0103, 8'hC0);
        rdx("R6 colour pair off", 16'h03D6, 1'b0, 8'hFF);
        wr(16'h03B6, 8'h41);
        wr(16'h03B7, 8'h99);
        rdx("R6 mono data", 16'h03B7, 1'b1, 8'h99);
        rdx("R6 mono index", 16'h03B6, 1'b1, 8'h41);
        rdx("R6 multi enable readback", 16'h0103, 1'b1, 8'hC0);

        rdx("R9 wide alias miss", 16'h43B6, 1'b0, 8'hFF);
        wr(16'h03B6, 8'h02);
        wr(16'h03B7, 8'h20);
        rdx("R9 narrow alias index", 16'h43B6, 1'b1, 8'h02);
        rdx("R9 narrow alias global id", 16'hC104, 1'b1, 8'hA5);
        wr(16'h7FB7, 8'h00);
        rdx("R9 back to wide", 16'h43B6, 1'b0, 8'hFF);

        wr(16'h46E8, 8'h08);
        chk("R2 setup left", {14'b0, setup_mode, adapter_en}, 16'h1);
        rdx("R3 multi enable hidden", 16'h0103, 1'b0, 8'hFF);
        wr(16'h0103, 8'h00);
        rdx("R3 hidden write kept gate open", 16'h03B7, 1'b1, 8'h00);

        rdx("R10 unmapped read", 16'h03C0, 1'b0, 8'hFF);
        wr(16'h03C0, 8'h12);
        chk("R10 unmapped write no strobe", {15'b0, ext_wr_stb}, 16'h0);
        chk("R10 unmapped write keeps flags", {13'b0, setup_mode, adapter_en, vga_en}, 16'h3);

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule